// File: doc/BRIEF.md
# Two-Level Masked Interrupt Controller

This block collects thirty-one peripheral request lines and turns them into two request outputs for a processor: an ordinary interrupt and a fast, higher-priority interrupt. Each level has its own enable mask. A source can be routed to one level, or to neither, but never to both at once. Software sees each level through four word registers: the synchronised raw requests, the enable mask, a write-only port that clears enable bits, and the masked view that drives the output. The block does no priority encoding and produces no vector. The handler reads the masked view and picks the source itself.

Request lines are level inputs. They pass through a two-flop synchroniser, and each peripheral drops its own line once serviced. Bit 0 of both levels is not a peripheral: it reports the fast-interrupt aggregate, so the ordinary level can see that a fast request is pending. A configuration register lets software raise one programmed request per level on bit 1. These programmed requests bypass the enable masks. The register port is a plain 32-bit word port addressed by word index. Reads are combinational, and writes take effect at the clock edge.

Top module: `dual_irq_ctrl`

## Requirements
- R1: Raw status bits 31..1 (normal at word 0, fast at word 4) equal `req_i[31:1]` delayed by a two-flop synchroniser; `req_i[0]` has no effect on any register or output.
- R2: Writing word 1 (normal enable) or word 5 (fast enable) sets every enable bit written as 1; bits written as 0 keep their value.
- R3: Writing word 2 (normal clear) or word 6 (fast clear) clears every enable bit of that level written as 1 and leaves the rest; both words read as zero.
- R4: The masked status word (normal word 3, fast word 7) reads as raw status AND enable, apart from the programmed bit of R9.
- R5: `irq_o` is a register holding the OR of all 32 bits of the normal masked status.
- R6: `fiq_o` is a register holding the OR of bits 31..1 of the fast masked status.
- R7: Setting an enable bit in one level clears the same bit in the other level; the two enable masks never share a set bit, and both may be clear.
- R8: Bit 0 of both raw status words reads the fast aggregate (OR of fast masked bits 31..1); it reaches `irq_o` only when normal enable bit 0 is set.
- R9: Configuration word 8 bit 1 forces bit 1 of the normal raw and masked status; bit 2 does the same for the fast level; both act regardless of the enable masks.
- R10: Configuration word 8 reads its bits 2 and 1 and zero elsewhere; writes to its other bits are ignored; words 9..15 read as zero.
- R11: After reset both enable masks and the configuration word are zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 32 | Peripheral request levels, bit 0 unused |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| irq_o | output | 1 | Normal interrupt request, registered |
| fiq_o | output | 1 | Fast interrupt request, registered |

## Verification
The assertions assume at most one register write per clock. That is what makes a single-cycle set or clear on an enable mask observable. The stimulus issues one bus access at a time, with idle cycles between accesses. The request lines are held stable for several cycles after each change, so the synchroniser and output registers settle before anything is sampled. Random enable, clear and configuration values are mixed with request patterns. Directed cases cover the cross-clear of the masks, the effect of request line 0, programmed requests with both masks empty, and the reserved bits.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;
  localparam int unsigned SWI_BIT = 1;

  typedef enum logic [AW-1:0] {
    A_NRM_RAW = 4'd0,
    A_NRM_EN  = 4'd1,
    A_NRM_CLR = 4'd2,
    A_NRM_MSK = 4'd3,
    A_FST_RAW = 4'd4,
    A_FST_EN  = 4'd5,
    A_FST_CLR = 4'd6,
    A_FST_MSK = 4'd7,
    A_SWCFG   = 4'd8
  } reg_idx_e;

  typedef struct packed {
    logic [DW-1:0] set_v;
    logic [DW-1:0] clr_v;
  } en_cmd_t;
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sn = sh_q[STAGES-1];
endmodule

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int unsigned W      = 31,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_sn,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        always_comb stg_d = din;
      end else begin : g_next
        always_comb stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_sn) begin
        if (!rst_sn) stg_q[s] <= '0;
        else         stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/intc_level.sv
module intc_level #(
  parameter int unsigned DW      = 32,
  parameter int unsigned SWI_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic [DW-1:0] set_v,
  input  logic [DW-1:0] clr_v,
  input  logic [DW-1:0] raw_i,
  input  logic          swi_i,
  output logic [DW-1:0] en_o,
  output logic [DW-1:0] msk_o
);
  logic [DW-1:0] en_q;
  logic [DW-1:0] en_d;
  logic          en_upd;
  logic [DW-1:0] swi_vec;

  always_comb begin
    en_upd = |(set_v | clr_v);
    en_d   = (en_q | set_v) & ~clr_v;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     en_q <= '0;
    else if (en_upd) en_q <= en_d;
  end

  always_comb begin
    swi_vec = {{(DW-1){1'b0}}, swi_i} << SWI_BIT;
    msk_o   = (raw_i & en_q) | swi_vec;
  end

  assign en_o = en_q;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> ((en_o & $past(set_v & ~clr_v)) == $past(set_v & ~clr_v))); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    ((set_v | clr_v) == '0) |=> $stable(en_o)); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> ((en_o & $past(clr_v)) == '0)); // R3
  AST_SWI_NONMASK: assert property (@(posedge clk) disable iff (!rst_sn)
    swi_i |-> msk_o[SWI_BIT]); // R9
endmodule

// File: rtl/intc_regif.sv
module intc_regif
  import intc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] nraw,
  input  logic [DW-1:0] nen,
  input  logic [DW-1:0] nmsk,
  input  logic [DW-1:0] fraw,
  input  logic [DW-1:0] fen,
  input  logic [DW-1:0] fmsk,
  output logic [DW-1:0] bus_rdata,
  output en_cmd_t       n_cmd,
  output en_cmd_t       f_cmd,
  output logic          swi_n,
  output logic          swi_f
);
  logic       wr;
  logic       rd;
  logic [2:1] sw_q;
  logic [2:1] sw_d;
  logic       sw_we;

  always_comb begin
    wr = bus_sel & bus_we;
    rd = bus_sel & ~bus_we;
    n_cmd = '0;
    f_cmd = '0;
    if (wr) begin
      unique case (bus_addr)
        A_NRM_EN: begin
          n_cmd.set_v = bus_wdata;
          f_cmd.clr_v = bus_wdata;
        end
        A_FST_EN: begin
          f_cmd.set_v = bus_wdata;
          n_cmd.clr_v = bus_wdata;
        end
        A_NRM_CLR: n_cmd.clr_v = bus_wdata;
        A_FST_CLR: f_cmd.clr_v = bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    sw_we = wr && (bus_addr == A_SWCFG);
    sw_d  = bus_wdata[2:1];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    sw_q <= '0;
    else if (sw_we) sw_q <= sw_d;
  end

  assign swi_n = sw_q[1];
  assign swi_f = sw_q[2];

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (bus_addr)
        A_NRM_RAW: bus_rdata = nraw;
        A_NRM_EN:  bus_rdata = nen;
        A_NRM_MSK: bus_rdata = nmsk;
        A_FST_RAW: bus_rdata = fraw;
        A_FST_EN:  bus_rdata = fen;
        A_FST_MSK: bus_rdata = fmsk;
        A_SWCFG:   bus_rdata = {{(DW-3){1'b0}}, sw_q, 1'b0};
        default:   bus_rdata = '0;
      endcase
    end
  end

  AST_SW_WRITE: assert property (@(posedge clk) disable iff (!rst_sn)
    sw_we |=> ({swi_f, swi_n} == $past(bus_wdata[2:1]))); // R9
  AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    !sw_we |=> $stable({swi_f, swi_n})); // R10
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl
  import intc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] req_i,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o,
  output logic          fiq_o
);
  localparam int unsigned NPER = DW - 1;

  logic            rst_sn;
  logic [NPER-1:0] req_s;
  logic            unused_req0;
  logic            unused_fmsk0;
  en_cmd_t         n_cmd;
  en_cmd_t         f_cmd;
  logic            swi_n;
  logic            swi_f;
  logic [DW-1:0]   swi_n_vec;
  logic [DW-1:0]   swi_f_vec;
  logic [DW-1:0]   fraw_pre;
  logic [DW-1:0]   fen;
  logic [DW-1:0]   fmsk_lv;
  logic            fagg;
  logic [DW-1:0]   fraw;
  logic [DW-1:0]   fmsk;
  logic [DW-1:0]   nraw;
  logic [DW-1:0]   nen;
  logic [DW-1:0]   nmsk;
  logic            irq_d;
  logic            fiq_d;
  logic            irq_q;
  logic            fiq_q;

  assign unused_req0 = req_i[0];

  intc_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  intc_sync #(.W(NPER), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_sn (rst_sn),
    .din    (req_i[DW-1:1]),
    .dout   (req_s)
  );

  always_comb begin
    swi_n_vec = {{(DW-1){1'b0}}, swi_n} << SWI_BIT;
    swi_f_vec = {{(DW-1){1'b0}}, swi_f} << SWI_BIT;
    fraw_pre  = {req_s, 1'b0} | swi_f_vec;
  end

  intc_level #(.DW(DW), .SWI_BIT(SWI_BIT)) u_fst (
    .clk    (clk),
    .rst_sn (rst_sn),
    .set_v  (f_cmd.set_v),
    .clr_v  (f_cmd.clr_v),
    .raw_i  (fraw_pre),
    .swi_i  (swi_f),
    .en_o   (fen),
    .msk_o  (fmsk_lv)
  );

  assign unused_fmsk0 = fmsk_lv[0];

  always_comb begin
    fagg = |fmsk_lv[DW-1:1];
    fraw = {fraw_pre[DW-1:1], fagg};
    fmsk = {fmsk_lv[DW-1:1], fagg & fen[0]};
    nraw = {req_s, fagg} | swi_n_vec;
  end

  intc_level #(.DW(DW), .SWI_BIT(SWI_BIT)) u_nrm (
    .clk    (clk),
    .rst_sn (rst_sn),
    .set_v  (n_cmd.set_v),
    .clr_v  (n_cmd.clr_v),
    .raw_i  (nraw),
    .swi_i  (swi_n),
    .en_o   (nen),
    .msk_o  (nmsk)
  );

  intc_regif u_regs (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .nraw      (nraw),
    .nen       (nen),
    .nmsk      (nmsk),
    .fraw      (fraw),
    .fen       (fen),
    .fmsk      (fmsk),
    .bus_rdata (bus_rdata),
    .n_cmd     (n_cmd),
    .f_cmd     (f_cmd),
    .swi_n     (swi_n),
    .swi_f     (swi_f)
  );

  always_comb begin
    irq_d = |nmsk;
    fiq_d = fagg;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end

  assign irq_o = irq_q;
  assign fiq_o = fiq_q;

  AST_EN_EXCL: assert property (@(posedge clk) disable iff (!rst_sn)
    ((nen & fen) == '0)); // R7
  AST_IRQ_OUT: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> (irq_o == $past(|nmsk))); // R5
  AST_FIQ_OUT: assert property (@(posedge clk) disable iff (!rst_sn)
    1'b1 |=> (fiq_o == $past(|fmsk[DW-1:1]))); // R6
  AST_AGG_SEEN: assert property (@(posedge clk) disable iff (!rst_sn)
    (|fmsk[DW-1:1]) |-> (nraw[0] && fraw[0])); // R8
endmodule

// File: tb/test_dual_irq_ctrl.sv
module test_dual_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] req_i;
  logic        bus_sel;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;
  logic        fiq_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_req, m_nen, m_fen;
  logic [2:1]  m_sw;

  always #10 clk = ~clk;

  dual_irq_ctrl i_dual_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  function automatic logic [31:0] e_fhi();
    logic [31:0] pre = (m_req & 32'hFFFF_FFFE) | ({31'd0, m_sw[2]} << 1);
    return (pre & m_fen) | ({31'd0, m_sw[2]} << 1);
  endfunction
  function automatic logic e_agg();
    logic [31:0] h = e_fhi();
    return |h[31:1];
  endfunction
  function automatic logic [31:0] e_fraw();
    return (m_req & 32'hFFFF_FFFE) | ({31'd0, m_sw[2]} << 1) | {31'd0, e_agg()};
  endfunction
  function automatic logic [31:0] e_fmsk();
    return (e_fraw() & m_fen) | ({31'd0, m_sw[2]} << 1);
  endfunction
  function automatic logic [31:0] e_nraw();
    return (m_req & 32'hFFFF_FFFE) | ({31'd0, m_sw[1]} << 1) | {31'd0, e_agg()};
  endfunction
  function automatic logic [31:0] e_nmsk();
    return (e_nraw() & m_nen) | ({31'd0, m_sw[1]} << 1);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    case (a)
      4'd1: begin m_nen = m_nen | d; m_fen = m_fen & ~d; end
      4'd5: begin m_fen = m_fen | d; m_nen = m_nen & ~d; end
      4'd2: m_nen = m_nen & ~d;
      4'd6: m_fen = m_fen & ~d;
      4'd8: m_sw = d[2:1];
      default: ;
    endcase
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all();
    logic [31:0] v;
    rd(4'd0, v); chk("R1/R8 normal raw", v, e_nraw());
    rd(4'd1, v); chk("R2/R7 normal enable", v, m_nen);
    rd(4'd2, v); chk("R3 normal clear reads zero", v, 32'd0);
    rd(4'd3, v); chk("R4/R9 normal masked", v, e_nmsk());
    rd(4'd4, v); chk("R1/R8 fast raw", v, e_fraw());
    rd(4'd5, v); chk("R2/R7 fast enable", v, m_fen);
    rd(4'd6, v); chk("R3 fast clear reads zero", v, 32'd0);
    rd(4'd7, v); chk("R4/R9 fast masked", v, e_fmsk());
    rd(4'd8, v); chk("R10 config word", v, {29'd0, m_sw, 1'b0});
    chk("R5 irq_o", {31'd0, irq_o}, {31'd0, |e_nmsk()});
    chk("R6 fiq_o", {31'd0, fiq_o}, {31'd0, e_agg()});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    rst_n = 1'b0; req_i = '0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    m_req = 0; m_nen = 0; m_fen = 0; m_sw = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    settle();
    // R11 reset state
    check_all();
    chk("R11 irq low", {31'd0, irq_o}, 32'd0);

    // R1: line 0 alone changes nothing
    req_i = 32'h0000_0001; m_req = req_i; wr(4'd1, 32'hFFFF_FFFF); settle();
    chk("R1 line0 no irq", {31'd0, irq_o}, 32'd0);
    check_all();

    // R7 cross-clear
    wr(4'd5, 32'h0000_FF00); settle(); check_all();
    // R2 zero write no change
    wr(4'd1, 32'd0); wr(4'd5, 32'd0); settle(); check_all();
    // R3 clear subset
    wr(4'd2, 32'hF0F0_0000); settle(); check_all();
    // R9 programmed requests with empty masks
    wr(4'd2, 32'hFFFF_FFFF); wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd8, 32'hFFFF_FFFF); settle(); check_all();
    chk("R9 irq from programmed", {31'd0, irq_o}, 32'd1);
    chk("R9 fiq from programmed", {31'd0, fiq_o}, 32'd1);
    // R8 aggregate reaches irq only with normal bit 0
    wr(4'd8, 32'd4); settle(); check_all();
    chk("R8 agg masked from irq", {31'd0, irq_o}, 32'd0);
    wr(4'd1, 32'd1); settle(); check_all();
    chk("R8 agg through bit0", {31'd0, irq_o}, 32'd1);
    wr(4'd8, 32'd0);
    // R10 unmapped reads
    for (int a = 9; a < 16; a++) begin
      rd(a[3:0], v); chk("R10 unmapped read", v, 32'd0);
    end

    for (int i = 0; i < 400; i++) begin
      logic [31:0] d = $urandom;
      case ($urandom % 7)
        0: wr(4'd1, d);
        1: wr(4'd2, d);
        2: wr(4'd5, d);
        3: wr(4'd6, d);
        4: wr(4'd8, d);
        5: wr(4'd1, d & $urandom);
        default: begin
          @(negedge clk);
          req_i = ($urandom % 3 == 0) ? (d & $urandom & $urandom) : d;
          m_req = req_i;
        end
      endcase
      settle();
      check_all();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule